// File: doc/BRIEF.md
# Segment Logical-to-Linear Address Translator

This block turns a logical address, made of a 16-bit segment selector and an effective offset, into a linear address. It keeps a small cache of six segment slots. Each slot holds the loaded selector, a base and a null marker. A load request names a slot and a selector. An access request names a slot and an offset, and one cycle later the block returns the linear address and a fault flag.

Three translation modes are selected by `mode`. In real mode (0) the base is the selector times 16 and the result wraps at 1 MB. In protected mode (1) a load decodes the selector, checks it against a descriptor table held in memory, and fetches one descriptor over a request/acknowledge read port. The returned base and attributes are then checked and cached. In long mode (2) the table entries are 16 bytes apart, and every slot except 4 and 5 translates with a zero base.

A load that fails its checks returns a fault code and leaves its slot untouched. Slot 1 is the code segment: the low two bits of its cached selector give the current privilege level (CPL).

Top module: `seg_xlat_top`

## Requirements
- R1: After reset every slot has selector 0, base 0 and no null marker, so the CPL is 0. In the same state `ld_ready`=1, `mem_req`=0, `ld_done`=0 and `lin_valid`=0.
- R2: In mode 0 a load takes effect with fault 0 and no memory read. The access result is (selector*16 + offset[15:0]) mod 2^20.
- R3: The selector fields are RPL = bits [1:0], table indicator = bit 2 and index = bits [15:3]. In modes 1 and 2 a load issues exactly one read at table base + index*8 (mode 1) or base + index*16 (mode 2). `mem_req` and `mem_addr` stay steady until `mem_ack`. The returned data carries the base in bits [31:0], the present flag in bit 32 and the DPL in bits [34:33].
- R4: If byte offset + 7 > `tbl_limit`, the load ends with fault code 1 and no read. The byte offset is index*8 in mode 1 and index*16 in mode 2.
- R5: A selector with index 0 and indicator 0 loads with fault 0 and no read. Any later mode 1 or 2 access through that slot raises `acc_fault`.
- R6: A selector with bit 2 set ends with fault code 4 and no read.
- R7: A descriptor whose present bit is 0 ends the load with fault code 2.
- R8: A load into any slot but 1 ends with fault code 3 when max(CPL, RPL) > DPL. Slot 1 loads skip this check.
- R9: A load that faults leaves the slot's selector, base and null marker unchanged.
- R10: In mode 1 the access result is base + offset mod 2^32.
- R11: In mode 2 slots 0 to 3 return the offset unchanged, and slots 4 and 5 return base + offset.
- R12: `ld_done` is a one-cycle pulse. It comes one cycle after an accepted load that needs no read, or one cycle after the acknowledge. `ld_ready` is low while the read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode | input | 2 | 0 real, 1 protected, 2 long |
| tbl_base | input | 32 | Descriptor table base address |
| tbl_limit | input | 16 | Last valid byte offset of the table |
| ld_valid | input | 1 | Load request |
| ld_seg | input | 3 | Slot to load (0..5) |
| ld_sel | input | 16 | Selector to load |
| ld_ready | output | 1 | Load can be accepted |
| ld_done | output | 1 | Load finished (pulse) |
| ld_fault | output | 3 | Load fault code, valid with ld_done |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Descriptor address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 35 | Descriptor fields |
| acc_valid | input | 1 | Access request |
| acc_seg | input | 3 | Slot used by the access |
| acc_off | input | 32 | Effective offset |
| lin_valid | output | 1 | Access result valid |
| lin_addr | output | 32 | Linear address |
| acc_fault | output | 1 | Access through a null slot |

## Verification
Directed loads place selectors on each side of the table limit in both entry sizes. They make the RPL, the CPL or the DPL the deciding term of the privilege check, and they reload the code slot to move the CPL. Real-mode cases use offsets with high bits set and selectors that overflow 1 MB. This shows whether truncation and wrap happen at the right width. Random loads and accesses in all three modes are compared against a bench model of the slot cache. The model counts memory reads and checks their addresses, which shows whether a rejected load touched memory or the cache.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;
    localparam int SEL_W   = 16;
    localparam int ADDR_W  = 32;
    localparam int LIM_W   = 16;
    localparam int NSEG    = 6;
    localparam int SEGID_W = 3;
    localparam int DESC_W  = ADDR_W + 3;

    localparam logic [SEGID_W-1:0] SEG_CODE   = 3'd1;
    localparam logic [SEGID_W-1:0] SEG_KEEP_A = 3'd4;
    localparam logic [SEGID_W-1:0] SEG_KEEP_B = 3'd5;

    typedef enum logic [1:0] {
        MODE_REAL = 2'd0,
        MODE_PROT = 2'd1,
        MODE_LONG = 2'd2
    } xmode_e;

    typedef enum logic [2:0] {
        FLT_NONE    = 3'd0,
        FLT_LIMIT   = 3'd1,
        FLT_NOTPRES = 3'd2,
        FLT_PRIV    = 3'd3,
        FLT_TABLE   = 3'd4
    } lfault_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } st_e;

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [ADDR_W-1:0] base;
        logic              nul;
    } seg_entry_t;
endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode
    import seg_xlat_pkg::*;
(
    input  logic [SEL_W-1:0]  sel,
    input  logic              wide_ent,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [LIM_W-1:0]  tbl_limit,
    output logic [1:0]        rpl,
    output logic              ti,
    output logic              is_null,
    output logic              lim_ok,
    output logic [ADDR_W-1:0] desc_addr
);
    localparam int IDX_W = SEL_W - 3;
    localparam int OFS_W = IDX_W + 4;
    localparam int CMP_W = (OFS_W + 1 > LIM_W) ? OFS_W + 1 : LIM_W;

    logic [IDX_W-1:0] idx;
    logic [OFS_W-1:0] ofs;
    logic [CMP_W-1:0] last_byte;

    always_comb begin
        rpl       = sel[1:0];
        ti        = sel[2];
        idx       = sel[SEL_W-1:3];
        is_null   = (idx == '0) && !ti;
        ofs       = wide_ent ? {idx, 4'b0000} : {1'b0, idx, 3'b000};
        last_byte = CMP_W'(ofs) + CMP_W'(7);
        lim_ok    = last_byte <= CMP_W'(tbl_limit);
        desc_addr = tbl_base + ADDR_W'(ofs);
    end
endmodule

// File: rtl/seg_priv_check.sv
module seg_priv_check
    import seg_xlat_pkg::*;
(
    input  logic       is_code,
    input  logic [1:0] cpl,
    input  logic [1:0] rpl,
    input  logic [1:0] dpl,
    input  logic       present,
    output lfault_e    fault
);
    logic [1:0] eff;

    always_comb begin
        eff = (cpl > rpl) ? cpl : rpl;
        if (!present)
            fault = FLT_NOTPRES;
        else if (!is_code && (eff > dpl))
            fault = FLT_PRIV;
        else
            fault = FLT_NONE;
    end
endmodule

// File: rtl/seg_lin_calc.sv
module seg_lin_calc
    import seg_xlat_pkg::*;
(
    input  logic [1:0]         mode,
    input  logic [SEGID_W-1:0] seg,
    input  logic [ADDR_W-1:0]  base,
    input  logic               nul,
    input  logic [ADDR_W-1:0]  off,
    output logic [ADDR_W-1:0]  lin,
    output logic               null_flt
);
    localparam int REAL_W = 20;

    logic flat;
    logic [REAL_W-1:0] real_sum;

    always_comb begin
        flat     = (mode == MODE_LONG) && (seg != SEG_KEEP_A) && (seg != SEG_KEEP_B);
        real_sum = base[REAL_W-1:0] + REAL_W'(off[15:0]);
        if (mode == MODE_REAL)
            lin = ADDR_W'(real_sum);
        else if (flat)
            lin = off;
        else
            lin = base + off;
        null_flt = (mode != MODE_REAL) && nul;
    end
endmodule

// File: rtl/seg_xlat_top.sv
module seg_xlat_top
    import seg_xlat_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         mode,
    input  logic [ADDR_W-1:0]  tbl_base,
    input  logic [LIM_W-1:0]   tbl_limit,
    input  logic               ld_valid,
    input  logic [SEGID_W-1:0] ld_seg,
    input  logic [SEL_W-1:0]   ld_sel,
    output logic               ld_ready,
    output logic               ld_done,
    output logic [2:0]         ld_fault,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic               mem_ack,
    input  logic [DESC_W-1:0]  mem_rdata,
    input  logic               acc_valid,
    input  logic [SEGID_W-1:0] acc_seg,
    input  logic [ADDR_W-1:0]  acc_off,
    output logic               lin_valid,
    output logic [ADDR_W-1:0]  lin_addr,
    output logic               acc_fault
);
    typedef struct packed {
        st_e                         st;
        seg_entry_t [NSEG-1:0]       segs;
        logic [SEGID_W-1:0]          pend_seg;
        logic [SEL_W-1:0]            pend_sel;
        logic [1:0]                  pend_rpl;
        logic                        mem_req;
        logic [ADDR_W-1:0]           mem_addr;
        logic                        ld_done;
        lfault_e                     ld_fault;
        logic                        lin_valid;
        logic [ADDR_W-1:0]           lin_addr;
        logic                        acc_fault;
    } state_t;

    state_t q, d;

    logic              is_real, wide;
    logic [1:0]        dec_rpl;
    logic              dec_ti, dec_null, dec_lim_ok;
    logic [ADDR_W-1:0] dec_addr;
    lfault_e           pf;
    seg_entry_t        acc_ent;
    logic [ADDR_W-1:0] lin_w;
    logic              nulf_w;
    logic              wr_en;
    logic [SEGID_W-1:0] wr_seg;
    seg_entry_t        wr_ent;

    assign is_real = (mode == MODE_REAL);
    assign wide    = (mode == MODE_LONG);

    seg_sel_decode u_dec (
        .sel       (ld_sel),
        .wide_ent  (wide),
        .tbl_base  (tbl_base),
        .tbl_limit (tbl_limit),
        .rpl       (dec_rpl),
        .ti        (dec_ti),
        .is_null   (dec_null),
        .lim_ok    (dec_lim_ok),
        .desc_addr (dec_addr)
    );

    seg_priv_check u_priv (
        .is_code (q.pend_seg == SEG_CODE),
        .cpl     (q.segs[SEG_CODE].sel[1:0]),
        .rpl     (q.pend_rpl),
        .dpl     (mem_rdata[ADDR_W+2:ADDR_W+1]),
        .present (mem_rdata[ADDR_W]),
        .fault   (pf)
    );

    always_comb begin
        acc_ent = '0;
        for (int i = 0; i < NSEG; i++)
            if (SEGID_W'(i) == acc_seg) acc_ent = q.segs[i];
    end

    seg_lin_calc u_lin (
        .mode     (mode),
        .seg      (acc_seg),
        .base     (acc_ent.base),
        .nul      (acc_ent.nul),
        .off      (acc_off),
        .lin      (lin_w),
        .null_flt (nulf_w)
    );

    always_comb begin
        d            = q;
        d.ld_done    = 1'b0;
        d.ld_fault   = FLT_NONE;
        d.lin_valid  = 1'b0;
        d.acc_fault  = 1'b0;
        wr_en        = 1'b0;
        wr_seg       = ld_seg;
        wr_ent       = '0;

        if (acc_valid) begin
            d.lin_valid = 1'b1;
            d.lin_addr  = lin_w;
            d.acc_fault = nulf_w;
        end

        case (q.st)
            ST_IDLE: begin
                if (ld_valid) begin
                    if (is_real) begin
                        d.ld_done = 1'b1;
                        wr_en     = 1'b1;
                        wr_ent    = '{sel: ld_sel, base: ADDR_W'({ld_sel, 4'b0000}), nul: 1'b0};
                    end else if (dec_ti) begin
                        d.ld_done  = 1'b1;
                        d.ld_fault = FLT_TABLE;
                    end else if (dec_null) begin
                        d.ld_done = 1'b1;
                        wr_en     = 1'b1;
                        wr_ent    = '{sel: ld_sel, base: '0, nul: 1'b1};
                    end else if (!dec_lim_ok) begin
                        d.ld_done  = 1'b1;
                        d.ld_fault = FLT_LIMIT;
                    end else begin
                        d.st       = ST_FETCH;
                        d.pend_seg = ld_seg;
                        d.pend_sel = ld_sel;
                        d.pend_rpl = dec_rpl;
                        d.mem_req  = 1'b1;
                        d.mem_addr = dec_addr;
                    end
                end
            end
            ST_FETCH: begin
                if (mem_ack) begin
                    d.st       = ST_IDLE;
                    d.mem_req  = 1'b0;
                    d.ld_done  = 1'b1;
                    d.ld_fault = pf;
                    if (pf == FLT_NONE) begin
                        wr_en  = 1'b1;
                        wr_seg = q.pend_seg;
                        wr_ent = '{sel: q.pend_sel, base: mem_rdata[ADDR_W-1:0], nul: 1'b0};
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase

        for (int i = 0; i < NSEG; i++)
            if (wr_en && (SEGID_W'(i) == wr_seg)) d.segs[i] = wr_ent;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ld_ready  = (q.st == ST_IDLE);
    assign ld_done   = q.ld_done;
    assign ld_fault  = q.ld_fault;
    assign mem_req   = q.mem_req;
    assign mem_addr  = q.mem_addr;
    assign lin_valid = q.lin_valid;
    assign lin_addr  = q.lin_addr;
    assign acc_fault = q.acc_fault;

    // R3
    mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R12
    ld_done_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_done |-> ($past(ld_valid && ld_ready) || $past(mem_req && mem_ack)));

    // R11
    long_flat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lin_valid && !acc_fault && ($past(mode) == MODE_LONG) && ($past(acc_seg) < SEG_KEEP_A))
        |-> (lin_addr == $past(acc_off)));

    // R2
    real_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lin_valid && ($past(mode) == MODE_REAL)) |-> (lin_addr[ADDR_W-1:20] == '0));

    // R5
    null_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_fault |-> (lin_valid && ($past(mode) != MODE_REAL)));
endmodule

// File: tb/tb_seg_xlat_top.sv
module tb_seg_xlat_top;
    import seg_xlat_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [31:0] tbl_base = 32'h0001_0000;
    logic [15:0] tbl_limit = 16'h00FF;
    logic        ld_valid = 1'b0;
    logic [2:0]  ld_seg = '0;
    logic [15:0] ld_sel = '0;
    logic        ld_ready, ld_done;
    logic [2:0]  ld_fault;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [34:0] mem_rdata = '0;
    logic        acc_valid = 1'b0;
    logic [2:0]  acc_seg = '0;
    logic [31:0] acc_off = '0;
    logic        lin_valid;
    logic [31:0] lin_addr;
    logic        acc_fault;

    always #2 clk = ~clk;

    seg_xlat_top dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .tbl_base(tbl_base), .tbl_limit(tbl_limit),
        .ld_valid(ld_valid), .ld_seg(ld_seg), .ld_sel(ld_sel), .ld_ready(ld_ready),
        .ld_done(ld_done), .ld_fault(ld_fault), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .acc_valid(acc_valid), .acc_seg(acc_seg),
        .acc_off(acc_off), .lin_valid(lin_valid), .lin_addr(lin_addr), .acc_fault(acc_fault)
    );

    int checks = 0;
    int fails = 0;
    int nreads = 0;
    int dly = 0;
    bit finished = 0;
    logic [31:0] last_raddr = '0;
    logic [31:0] m_base [6];
    bit          m_nul  [6];
    logic [15:0] m_sel  [6];

    function automatic logic [34:0] desc_of(input logic [31:0] a);
        logic [31:0] b;
        logic        p;
        logic [1:0]  dp;
        b  = (a * 32'h0001_0003) ^ 32'hA5A0_0000;
        p  = (a[7:4] != 4'd5);
        dp = a[9:8] ^ a[5:4];
        return {dp, p, b};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // descriptor memory model
    initial begin
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (mem_req) begin
                if (dly == 0) begin
                    mem_ack    = 1'b1;
                    mem_rdata  = desc_of(mem_addr);
                    last_raddr = mem_addr;
                    nreads++;
                    dly = $urandom % 3;
                end else begin
                    dly--;
                end
            end
        end
    end

    task automatic do_load(input logic [2:0] seg, input logic [15:0] sel, input string tag);
        int          exp_f;
        bit          fetch;
        logic [31:0] ofs, ea;
        logic [34:0] ds;
        logic [1:0]  cpl, eff;
        int          n0, cyc;
        exp_f = 0; fetch = 0; ea = '0;
        cpl = m_sel[1][1:0];
        if (mode != 2'd0) begin
            ofs = (mode == 2'd2) ? 32'(sel[15:3]) * 16 : 32'(sel[15:3]) * 8;
            if (sel[2]) exp_f = 4;
            else if (sel[15:3] == 0) exp_f = 0;
            else if (ofs + 7 > 32'(tbl_limit)) exp_f = 1;
            else begin
                fetch = 1;
                ea = tbl_base + ofs;
                ds = desc_of(ea);
                eff = (cpl > sel[1:0]) ? cpl : sel[1:0];
                if (!ds[32]) exp_f = 2;
                else if (seg != 3'd1 && eff > ds[34:33]) exp_f = 3;
            end
        end
        n0 = nreads;
        ld_valid = 1'b1; ld_seg = seg; ld_sel = sel;
        @(negedge clk);
        ld_valid = 1'b0;
        cyc = 0;
        while (!ld_done && cyc < 50) begin
            @(negedge clk);
            cyc++;
        end
        chk(ld_done, {tag, " R12 done seen"}, 64'(ld_done), 64'd1);
        chk(int'(ld_fault) == exp_f, {tag, " fault code R4 R6 R7 R8"}, 64'(ld_fault), 64'(exp_f));
        chk((nreads - n0) == int'(fetch), {tag, " read count R2 R3 R4 R5 R6"}, 64'(nreads - n0), 64'(fetch));
        if (fetch) chk(last_raddr == ea, {tag, " descriptor address R3"}, 64'(last_raddr), 64'(ea));
        else chk(cyc == 0, {tag, " immediate done R12"}, 64'(cyc), 64'd0);
        if (exp_f == 0) begin
            m_sel[seg] = sel;
            if (mode == 2'd0) begin
                m_base[seg] = 32'({sel, 4'b0}); m_nul[seg] = 0;
            end else if (!fetch) begin
                m_base[seg] = '0; m_nul[seg] = 1;
            end else begin
                m_base[seg] = ds[31:0]; m_nul[seg] = 0;
            end
        end
        @(negedge clk);
        chk(ld_done == 1'b0, {tag, " done pulse width R12"}, 64'(ld_done), 64'd0);
    endtask

    task automatic do_acc(input logic [2:0] seg, input logic [31:0] off, input string tag);
        bit          nf;
        logic [31:0] e;
        nf = (mode != 2'd0) && m_nul[seg];
        if (mode == 2'd0) e = 32'(20'(m_base[seg][19:0] + 20'(off[15:0])));
        else if (mode == 2'd2 && seg < 3'd4) e = off;
        else e = m_base[seg] + off;
        acc_valid = 1'b1; acc_seg = seg; acc_off = off;
        @(negedge clk);
        acc_valid = 1'b0;
        chk(lin_valid, {tag, " lin_valid"}, 64'(lin_valid), 64'd1);
        chk(acc_fault == nf, {tag, " null fault R5"}, 64'(acc_fault), 64'(nf));
        if (!nf) chk(lin_addr == e, {tag, " linear R2 R10 R11"}, 64'(lin_addr), 64'(e));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog R12 actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd12345));
        for (int i = 0; i < 6; i++) begin m_base[i] = '0; m_nul[i] = 0; m_sel[i] = '0; end
        repeat (3) @(negedge clk);
        chk(ld_ready == 1'b1, "R1 reset ld_ready", 64'(ld_ready), 64'd1);
        chk(mem_req == 1'b0, "R1 reset mem_req", 64'(mem_req), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(lin_valid == 1'b0 && ld_done == 1'b0, "R1 idle outputs", 64'({lin_valid, ld_done}), 64'd0);
        do_acc(3'd2, 32'h0000_1234, "R1 reset base zero");

        // real mode
        mode = 2'd0;
        do_load(3'd3, 16'hF000, "R2 load");
        do_acc(3'd3, 32'h0000_FFFF, "R2 top of 1MB");
        do_load(3'd3, 16'hFFFF, "R2 load high");
        do_acc(3'd3, 32'h0000_0010, "R2 wrap");
        do_acc(3'd3, 32'hABCD_0001, "R2 offset truncation");

        // protected mode
        mode = 2'd1; tbl_base = 32'h0001_0000; tbl_limit = 16'h00FF;
        do_load(3'd2, {13'd3, 3'b000}, "R10 load");
        do_acc(3'd2, 32'h1000_0042, "R10 access");
        do_load(3'd2, {13'd10, 3'b000}, "R7 not present");
        do_acc(3'd2, 32'h0000_0042, "R9 after R7");
        do_load(3'd2, {13'd3, 3'b100}, "R6 table bit");
        do_acc(3'd2, 32'h0000_0042, "R9 after R6");
        do_load(3'd2, {13'd32, 3'b000}, "R4 limit over");
        do_acc(3'd2, 32'h0000_0042, "R9 after R4");
        do_load(3'd0, {13'd31, 3'b000}, "R4 limit edge");
        do_load(3'd3, {13'd1, 3'b011}, "R8 rpl over dpl");
        do_load(3'd1, {13'd1, 3'b011}, "R8 code exempt");
        do_load(3'd3, {13'd6, 3'b000}, "R8 cpl equal dpl");
        do_load(3'd4, {13'd2, 3'b000}, "R8 cpl over dpl");
        do_load(3'd1, {13'd6, 3'b000}, "R8 cpl back to zero");
        do_load(3'd5, 16'h0003, "R5 null load");
        do_acc(3'd5, 32'h0000_0100, "R5 null access");

        // long mode
        mode = 2'd2; tbl_base = 32'h0002_0000; tbl_limit = 16'h0057;
        do_load(3'd3, {13'd5, 3'b000}, "R4 long edge entry5");
        do_load(3'd3, {13'd6, 3'b000}, "R4 long over entry6");
        do_load(3'd4, {13'd2, 3'b000}, "R11 keep base load");
        do_acc(3'd4, 32'h0000_0777, "R11 keep base");
        do_load(3'd0, {13'd3, 3'b000}, "R11 flat load");
        do_acc(3'd0, 32'h1234_5678, "R11 flat");

        // random mix
        for (int m = 0; m < 3; m++) begin
            mode = 2'(m);
            tbl_limit = (m == 2) ? 16'h0057 : 16'h00FF;
            for (int k = 0; k < 150; k++) begin
                logic [2:0]  s;
                logic [15:0] sl;
                s = 3'($urandom % 6);
                if ($urandom % 2) begin
                    sl = {13'($urandom % 41), (($urandom % 8) == 0) ? 1'b1 : 1'b0, 2'($urandom)};
                    do_load(s, sl, "R3 R8 random load");
                end else begin
                    do_acc(s, $urandom, "R10 R11 random access");
                end
            end
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule